// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns a software-issued interrupt command into the set of agents that must receive it. A system holds a parameterised number of interrupt agents. Each agent has an identifier byte, a logical-address byte, a four-bit addressing model and a presence flag. Software first writes the high command word, which carries the target byte. It then writes the low command word. That second write decodes the vector, delivery kind, addressing mode, level, trigger and shorthand fields, and launches resolution.

One clock after the low-word write, the block presents a registered result. The result is an N-bit delivery mask, a one-hot mask naming a single winner for lowest-priority delivery, and the decoded vector, delivery kind and trigger. It also gives one of two strobes. The first announces an ordinary send. The second announces an arbitration-identifier resync request to the selected agents. Delivering into each agent and moving the message across a bus are left to the surrounding logic.

Top module: `ipi_dest_resolver`

## Requirements
- R1: After reset, deliverMask, lowPriMask, sendStrobe and resyncStrobe are all zero.
- R2: Shorthand bits [19:18] of the low word decide the addressing. Code 0 uses the target byte, code 1 selects only the sender (senderIdx), code 2 selects every agent, and code 3 selects every agent but the sender.
- R3: With shorthand 0 and bit 11 clear (physical), a target of 0xFF selects all agents. Any other target selects each agent whose identifier equals it, and selects nobody when none matches.
- R4: With shorthand 0 and bit 11 set (logical), an agent with model 0xF (flat) matches when target AND its logical byte is nonzero.
- R5: In logical mode, an agent with model 0x0 (cluster) matches when the target's upper nibble equals the upper nibble of its logical byte and the two lower nibbles share a set bit.
- R6: In logical mode, an agent whose model is neither 0xF nor 0x0 never matches.
- R7: When delivery kind bits [10:8] equal 3'b001 (lowest priority), lowPriMask holds only the lowest-indexed set bit of deliverMask. For every other kind, lowPriMask is zero.
- R8: An agent whose agentPresent bit is clear never appears in deliverMask, whatever the addressing.
- R9: A low-word write raises exactly one strobe for one cycle, in the next cycle. In that cycle the block also shows vector = bits [7:0], deliveryMode = bits [10:8] and trigger = bit 15. The target byte is taken from bits [31:24] of the most recently written high word. Outputs hold between writes.
- R10: A low word with kind 3'b101 (INIT), level bit 14 clear and trigger bit 15 set raises resyncStrobe instead of sendStrobe, with the mask resolved as usual. An INIT with level set raises sendStrobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdHighWr | input | 1 | Write strobe for the high command word |
| cmdHighData | input | 32 | High command word; target byte in [31:24] |
| cmdLowWr | input | 1 | Write strobe for the low command word; launches resolution |
| cmdLowData | input | 32 | Low command word |
| senderIdx | input | IDX_W | Index of the agent issuing the command |
| agentId | input | 8*NUM_AGENTS | Identifier byte of each agent, agent i at [8i+7:8i] |
| agentLogical | input | 8*NUM_AGENTS | Logical-address byte of each agent |
| agentModel | input | 4*NUM_AGENTS | Addressing model of each agent (0xF flat, 0x0 cluster) |
| agentPresent | input | NUM_AGENTS | Presence flag of each agent |
| sendStrobe | output | 1 | One-cycle pulse: interrupt to deliver |
| resyncStrobe | output | 1 | One-cycle pulse: arbitration resync request |
| deliverMask | output | NUM_AGENTS | Resolved destination set |
| lowPriMask | output | NUM_AGENTS | One-hot winner for lowest-priority delivery |
| vector | output | 8 | Decoded vector |
| deliveryMode | output | 3 | Decoded delivery kind |
| trigger | output | 1 | Decoded trigger mode |

## Verification
A wrong stored target byte or a mis-decoded field changes deliverMask or the strobe choice in the very next cycle after the low-word write. It can therefore be seen one clock after the stimulus. Errors in a per-agent match term show up only for addressing patterns that hit that agent. For this reason each addressing path is driven with agent tables whose expected masks differ bit by bit. A broken lowest-priority scan shows up as a lowPriMask that is not one-hot, lies outside deliverMask, or names a higher index.

// File: rtl/ipi_resolver_pkg.sv
package ipi_resolver_pkg;
  localparam logic [2:0] KIND_LOWPRI = 3'b001;
  localparam logic [2:0] KIND_INIT   = 3'b101;
  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [7:0] TARGET_ALL    = 8'hFF;

  typedef enum logic [1:0] {
    SH_TARGET  = 2'd0,
    SH_SELF    = 2'd1,
    SH_ALL     = 2'd2,
    SH_OTHERS  = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] kind;
    logic       logical;
    logic       level;
    logic       trigger;
    shorthand_e shorthand;
  } cmdFields_t;

  typedef struct packed {
    logic fire;
    logic resync;
  } ctrlStrobe_t;
endpackage

// File: rtl/ipi_cmd_ctrl.sv
module ipi_cmd_ctrl
  import ipi_resolver_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdHighWr,
  input  logic [31:0] cmdHighData,
  input  logic        cmdLowWr,
  input  logic [31:0] cmdLowData,
  output ctrlStrobe_t strobe,
  output cmdFields_t  fields,
  output logic [7:0]  targetByte
);
  // Target byte held from the last high-word write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) targetByte <= '0;
    else if (cmdHighWr) targetByte <= cmdHighData[31:24];
  end

  always_comb begin
    fields.vector    = cmdLowData[7:0];
    fields.kind      = cmdLowData[10:8];
    fields.logical   = cmdLowData[11];
    fields.level     = cmdLowData[14];
    fields.trigger   = cmdLowData[15];
    fields.shorthand = shorthand_e'(cmdLowData[19:18]);
  end

  always_comb begin
    strobe.fire   = cmdLowWr;
    strobe.resync = cmdLowWr && (fields.kind == KIND_INIT) &&
                    !fields.level && fields.trigger;
  end
endmodule

// File: rtl/ipi_mask_datapath.sv
module ipi_mask_datapath
  import ipi_resolver_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  parameter int IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrlStrobe_t             strobe,
  input  cmdFields_t              fields,
  input  logic [7:0]              targetByte,
  input  logic [IDX_W-1:0]        senderIdx,
  input  logic [8*NUM_AGENTS-1:0] agentId,
  input  logic [8*NUM_AGENTS-1:0] agentLogical,
  input  logic [4*NUM_AGENTS-1:0] agentModel,
  input  logic [NUM_AGENTS-1:0]   agentPresent,
  output logic                    sendStrobe,
  output logic                    resyncStrobe,
  output logic [NUM_AGENTS-1:0]   deliverMask,
  output logic [NUM_AGENTS-1:0]   lowPriMask,
  output logic [7:0]              vector,
  output logic [2:0]              deliveryMode,
  output logic                    trigger
);
  logic [NUM_AGENTS-1:0] hitMask;
  logic [NUM_AGENTS-1:0] winnerMask;

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
    logic [7:0] idByte;
    logic [7:0] logByte;
    logic [3:0] model;
    logic       isSender;
    logic       physHit;
    logic       flatHit;
    logic       clusterHit;
    logic       addrHit;
    assign idByte   = agentId[8*i +: 8];
    assign logByte  = agentLogical[8*i +: 8];
    assign model    = agentModel[4*i +: 4];
    assign isSender = (senderIdx == IDX_W'(i));
    assign physHit  = (targetByte == TARGET_ALL) || (targetByte == idByte);
    assign flatHit  = (model == MODEL_FLAT) && ((targetByte & logByte) != 8'h00);
    assign clusterHit = (model == MODEL_CLUSTER) &&
                        (targetByte[7:4] == logByte[7:4]) &&
                        ((targetByte[3:0] & logByte[3:0]) != 4'h0);
    always_comb begin
      unique case (fields.shorthand)
        SH_SELF:   addrHit = isSender;
        SH_ALL:    addrHit = 1'b1;
        SH_OTHERS: addrHit = !isSender;
        default:   addrHit = fields.logical ? (flatHit || clusterHit) : physHit;
      endcase
    end
    assign hitMask[i] = addrHit && agentPresent[i];
  end

  // Lowest-index pick: scan downward so the last hit written is the lowest.
  always_comb begin
    winnerMask = '0;
    for (int i = NUM_AGENTS - 1; i >= 0; i--) begin
      if (hitMask[i]) begin
        winnerMask    = '0;
        winnerMask[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sendStrobe   <= 1'b0;
      resyncStrobe <= 1'b0;
      deliverMask  <= '0;
      lowPriMask   <= '0;
      vector       <= '0;
      deliveryMode <= '0;
      trigger      <= 1'b0;
    end else begin
      sendStrobe   <= strobe.fire && !strobe.resync;
      resyncStrobe <= strobe.resync;
      if (strobe.fire) begin
        deliverMask  <= hitMask;
        lowPriMask   <= (fields.kind == KIND_LOWPRI) ? winnerMask : '0;
        vector       <= fields.vector;
        deliveryMode <= fields.kind;
        trigger      <= fields.trigger;
      end
    end
  end
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_resolver_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  localparam int IDX_W = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmdHighWr,
  input  logic [31:0]             cmdHighData,
  input  logic                    cmdLowWr,
  input  logic [31:0]             cmdLowData,
  input  logic [IDX_W-1:0]        senderIdx,
  input  logic [8*NUM_AGENTS-1:0] agentId,
  input  logic [8*NUM_AGENTS-1:0] agentLogical,
  input  logic [4*NUM_AGENTS-1:0] agentModel,
  input  logic [NUM_AGENTS-1:0]   agentPresent,
  output logic                    sendStrobe,
  output logic                    resyncStrobe,
  output logic [NUM_AGENTS-1:0]   deliverMask,
  output logic [NUM_AGENTS-1:0]   lowPriMask,
  output logic [7:0]              vector,
  output logic [2:0]              deliveryMode,
  output logic                    trigger
);
  ctrlStrobe_t strobe;
  cmdFields_t  fields;
  logic [7:0]  targetByte;

  ipi_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmdHighWr(cmdHighWr), .cmdHighData(cmdHighData),
    .cmdLowWr(cmdLowWr), .cmdLowData(cmdLowData),
    .strobe(strobe), .fields(fields), .targetByte(targetByte)
  );

  ipi_mask_datapath #(.NUM_AGENTS(NUM_AGENTS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .fields(fields), .targetByte(targetByte),
    .senderIdx(senderIdx), .agentId(agentId), .agentLogical(agentLogical),
    .agentModel(agentModel), .agentPresent(agentPresent),
    .sendStrobe(sendStrobe), .resyncStrobe(resyncStrobe),
    .deliverMask(deliverMask), .lowPriMask(lowPriMask),
    .vector(vector), .deliveryMode(deliveryMode), .trigger(trigger)
  );
endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
  parameter int NUM_AGENTS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmdLowWr,
  input logic [NUM_AGENTS-1:0] agentPresent,
  input logic                  sendStrobe,
  input logic                  resyncStrobe,
  input logic [NUM_AGENTS-1:0] deliverMask,
  input logic [NUM_AGENTS-1:0] lowPriMask,
  input logic [2:0]            deliveryMode
);
  // R9: each low-word write yields exactly one strobe next cycle
  a_r9_write_gives_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmdLowWr |=> (sendStrobe != resyncStrobe));
  a_r9_no_write_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdLowWr |=> (!sendStrobe && !resyncStrobe));
  a_r9_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdLowWr |=> $stable(deliverMask));
  // R7: winner is one-hot, inside the mask, and only for lowest-priority kind
  a_r7_winner_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lowPriMask));
  a_r7_winner_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (lowPriMask & ~deliverMask) == '0);
  a_r7_winner_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (deliveryMode != 3'b001) |-> (lowPriMask == '0));
  // R8: absent agents never selected
  a_r8_absent_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (sendStrobe || resyncStrobe) |-> ((deliverMask & ~$past(agentPresent)) == '0));
endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.NUM_AGENTS(NUM_AGENTS)) u_chk (.*);

// File: tb/ipi_dest_resolver_bench.sv
module ipi_dest_resolver_bench;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdHighWr = 1'b0;
  logic [31:0] cmdHighData = '0;
  logic cmdLowWr = 1'b0;
  logic [31:0] cmdLowData = '0;
  logic [2:0] senderIdx = '0;
  logic [8*N-1:0] agentId = '0;
  logic [8*N-1:0] agentLogical = '0;
  logic [4*N-1:0] agentModel = '0;
  logic [N-1:0] agentPresent = '1;
  logic sendStrobe, resyncStrobe, trigger;
  logic [N-1:0] deliverMask, lowPriMask;
  logic [7:0] vector;
  logic [2:0] deliveryMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ipi_dest_resolver #(.NUM_AGENTS(N)) u_ipi_dest_resolver (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] lowWord(input logic [1:0] sh, input logic trig,
      input logic lvl, input logic logical, input logic [2:0] kind, input logic [7:0] vec);
    return {12'h0, sh, 2'b00, trig, lvl, 2'b00, logical, kind, vec};
  endfunction

  task automatic issue(input logic [7:0] target, input logic [31:0] low);
    @(negedge clk);
    cmdHighWr = 1'b1; cmdHighData = {target, 24'h0};
    @(negedge clk);
    cmdHighWr = 1'b0; cmdLowWr = 1'b1; cmdLowData = low;
    @(negedge clk);
    cmdLowWr = 1'b0;
  endtask

  task automatic setupIds();
    for (int i = 0; i < N; i++) begin
      agentId[8*i +: 8] = 8'h20 + 8'(i);
      agentLogical[8*i +: 8] = 8'h01 << i;
      agentModel[4*i +: 4] = 4'hF;
    end
    agentPresent = '1;
  endtask

  task automatic testReset();
    check("R1 mask", 32'(deliverMask), 0);
    check("R1 winner", 32'(lowPriMask), 0);
    check("R1 strobes", {30'h0, sendStrobe, resyncStrobe}, 0);
  endtask

  task automatic testShorthand();
    senderIdx = 3'd3;
    issue(8'h00, lowWord(2'd1, 0, 0, 0, 3'b000, 8'h40));
    check("R2 self", 32'(deliverMask), 32'h08);
    check("R9 send strobe", {30'h0, sendStrobe, resyncStrobe}, 32'h2);
    issue(8'h00, lowWord(2'd2, 0, 0, 0, 3'b000, 8'h40));
    check("R2 all", 32'(deliverMask), 32'hFF);
    senderIdx = 3'd2;
    issue(8'h21, lowWord(2'd3, 0, 0, 0, 3'b000, 8'h40));
    check("R2 others", 32'(deliverMask), 32'hFB);
  endtask

  task automatic testPhysical();
    issue(8'hFF, lowWord(2'd0, 0, 0, 0, 3'b000, 8'h41));
    check("R3 broadcast", 32'(deliverMask), 32'hFF);
    issue(8'h25, lowWord(2'd0, 0, 0, 0, 3'b000, 8'h41));
    check("R3 id match", 32'(deliverMask), 32'h20);
    issue(8'h77, lowWord(2'd0, 0, 0, 0, 3'b000, 8'h41));
    check("R3 no match", 32'(deliverMask), 32'h00);
  endtask

  task automatic testFlat();
    issue(8'h05, lowWord(2'd0, 0, 0, 1, 3'b000, 8'h42));
    check("R4 flat", 32'(deliverMask), 32'h05);
    issue(8'h05, lowWord(2'd0, 0, 0, 0, 3'b000, 8'h42));
    check("R3 same target physical", 32'(deliverMask), 32'h00);
  endtask

  task automatic testCluster();
    for (int i = 0; i < N; i++) begin
      agentModel[4*i +: 4] = 4'h0;
      agentLogical[8*i +: 8] = {4'(i >> 2), 4'h1 << (i & 3)};
    end
    issue(8'h13, lowWord(2'd0, 0, 0, 1, 3'b000, 8'h43));
    check("R5 cluster", 32'(deliverMask), 32'h30);
    issue(8'h0C, lowWord(2'd0, 0, 0, 1, 3'b000, 8'h43));
    check("R5 cluster zero", 32'(deliverMask), 32'h0C);
    setupIds();
  endtask

  task automatic testOtherModel();
    for (int i = 0; i < N; i++) agentLogical[8*i +: 8] = 8'hFF;
    agentModel[4*1 +: 4] = 4'h5;
    agentModel[4*6 +: 4] = 4'h8;
    issue(8'h01, lowWord(2'd0, 0, 0, 1, 3'b000, 8'h44));
    check("R6 unknown model", 32'(deliverMask), 32'hBD);
    setupIds();
  endtask

  task automatic testPresence();
    agentPresent = 8'hEF;
    issue(8'h00, lowWord(2'd2, 0, 0, 0, 3'b000, 8'h45));
    check("R8 absent all", 32'(deliverMask), 32'hEF);
    issue(8'h24, lowWord(2'd0, 0, 0, 0, 3'b000, 8'h45));
    check("R8 absent id", 32'(deliverMask), 32'h00);
    agentPresent = '1;
  endtask

  task automatic testLowPri();
    agentPresent = 8'hB0;
    issue(8'hFF, lowWord(2'd0, 0, 0, 0, 3'b001, 8'h46));
    check("R7 mask", 32'(deliverMask), 32'hB0);
    check("R7 winner", 32'(lowPriMask), 32'h10);
    agentPresent = '1;
    issue(8'h00, lowWord(2'd0, 0, 0, 1, 3'b001, 8'h46));
    check("R7 empty winner", 32'(lowPriMask), 32'h00);
    issue(8'hFF, lowWord(2'd0, 0, 0, 0, 3'b000, 8'h46));
    check("R7 fixed no winner", 32'(lowPriMask), 32'h00);
  endtask

  task automatic testDecode();
    issue(8'h22, lowWord(2'd0, 1, 1, 0, 3'b100, 8'h5A));
    check("R9 vector", 32'(vector), 32'h5A);
    check("R9 kind", 32'(deliveryMode), 32'h4);
    check("R9 trigger", 32'(trigger), 32'h1);
    check("R9 target", 32'(deliverMask), 32'h04);
    @(negedge clk);
    check("R9 strobe drops", {30'h0, sendStrobe, resyncStrobe}, 0);
    check("R9 hold", 32'(deliverMask), 32'h04);
  endtask

  task automatic testInit();
    issue(8'h23, lowWord(2'd0, 1, 0, 0, 3'b101, 8'h00));
    check("R10 resync", {30'h0, sendStrobe, resyncStrobe}, 32'h1);
    check("R10 resync mask", 32'(deliverMask), 32'h08);
    issue(8'h23, lowWord(2'd0, 1, 1, 0, 3'b101, 8'h00));
    check("R10 init asserted", {30'h0, sendStrobe, resyncStrobe}, 32'h2);
  endtask

  initial begin
    setupIds();
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    testShorthand();
    testPhysical();
    testFlat();
    testCluster();
    testOtherModel();
    testPresence();
    testLowPri();
    testDecode();
    testInit();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule